// File: doc/BRIEF.md
# Flash Busy-Status Read Responder

This block is the read path of a parallel flash model while an internal write is running and after it finishes. The command decoder, which is outside the block, pulses a start strobe with the kind of write (byte program, sector erase or chip erase) and, for a program, the byte being written. From then on a cycle-count timer holds the block busy for a per-kind number of clock cycles, standing in for the duration of the real operation.

On every read strobe the block returns one byte, registered, one clock after the strobe. While busy, that byte carries completion status inside ordinary data: the top bit answers a polling loop (the inverse of the top bit of the byte being programmed, or zero during any erase), and the bit below it flips on every successive read. Once the timer expires, reads return the true array contents supplied by the storage, so a polling loop sees the real byte and a steady second bit. When identification mode is on and no write is running, address 0 returns the maker code and address 1 returns a device code chosen by a density parameter.

The storage array and the command decoding sit outside the block; it only sees the true data for the addressed location and the flags the decoder gives it.

Top module: `flash_status_resp`

## Requirements
- R1: While reset is low, busy is 0 and rd_data is 00h; the toggle state restarts at 0.
- R2: A start pulse accepted while idle makes busy high for exactly PROG_CYC, SECT_CYC or CHIP_CYC cycles, starting the cycle after the start edge, for wr_op codes 0 (program), 1 (sector erase) and 2 (chip erase); code 3 starts nothing.
- R3: A start pulse while busy is ignored: busy still ends at the time set by the first start and no second operation follows.
- R4: A read while a program is busy returns bit 7 as the complement of bit 7 of wr_byte captured at the start.
- R5: A read while a sector or chip erase is busy returns bit 7 as 0.
- R6: A read while busy returns bit 6 from a toggle state that inverts after each such read and holds between reads, however many idle cycles separate them.
- R7: A read while idle, outside identification mode, returns array_data unchanged (an erased location reads FFh), so bit 6 no longer alternates.
- R8: While idle with id_mode high, a read at address 0 returns BFh, at address 1 returns D4h plus DEV_SEL (0 to 3), and at any other address returns array_data.
- R9: Status reporting takes priority over identification mode: an identification read during busy returns the status byte, not an ID code.
- R10: During busy, bits 5 to 0 of a read equal bits 5 to 0 of array_data.
- R11: rd_data changes only in the cycle after a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_start | input | 1 | Pulse from the decoder: begin an internal write |
| wr_op | input | 2 | Write kind: 0 program, 1 sector erase, 2 chip erase, 3 none |
| wr_byte | input | 8 | Byte being programmed, captured with wr_start |
| id_mode | input | 1 | Identification mode active |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| array_data | input | 8 | True array contents at rd_addr |
| rd_data | output | 8 | Byte returned for the last read strobe |
| busy | output | 1 | Internal write in progress |

## Verification
The assertions watch, on every cycle, the encoding of each busy read against the captured operation kind and program bit, the inversion and holding of the toggle state, the pass-through of the low bits and of idle data, and the hold of rd_data between strobes. Only the bench scenarios show the exact busy length for each kind, that a start issued mid-operation leaves the end time unchanged, the identification codes and their loss of priority to status, and that alternation resumes from the correct phase across operations; the behavioural model compared every clock covers the full sequence.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_CHIP = 2'd2,
        OP_NONE = 2'd3
    } op_kind_t;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned POLL_BIT = 7;
    localparam int unsigned TOG_BIT  = 6;

    localparam logic [BYTE_W-1:0] MAKER_CODE   = 8'hBF;
    localparam logic [BYTE_W-1:0] DEV_CODE_LOW = 8'hD4;

endpackage

// File: rtl/fsr_busy_timer.sv
module fsr_busy_timer
    import fsr_pkg::*;
#(
    parameter int unsigned PROG_CYC = 20,
    parameter int unsigned SECT_CYC = 100,
    parameter int unsigned CHIP_CYC = 400
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  op_kind_t op,
    input  logic     wr_msb,
    output logic     busy,
    output logic     is_prog,
    output logic     prog_msb
);

    localparam int unsigned MAX_AB  = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
    localparam int unsigned MAX_CYC = (MAX_AB > CHIP_CYC) ? MAX_AB : CHIP_CYC;
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        logic [CNT_W-1:0] remain;
        logic             prog;
        logic             msb;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [CNT_W-1:0] load_len;

    always_comb begin
        case (op)
            OP_PROG: load_len = CNT_W'(PROG_CYC);
            OP_SECT: load_len = CNT_W'(SECT_CYC);
            OP_CHIP: load_len = CNT_W'(CHIP_CYC);
            default: load_len = '0;
        endcase
    end

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.remain != '0) begin
            tmr_d.remain = tmr_q.remain - CNT_W'(1);
        end else if (start && (op != OP_NONE)) begin
            tmr_d.remain = load_len;
            tmr_d.prog   = (op == OP_PROG);
            tmr_d.msb    = wr_msb;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign busy     = (tmr_q.remain != '0);
    assign is_prog  = tmr_q.prog;
    assign prog_msb = tmr_q.msb;

endmodule

// File: rtl/fsr_toggle.sv
module fsr_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    output logic phase
);

    typedef struct packed {
        logic ph;
    } tog_t;

    tog_t tog_d, tog_q;

    always_comb begin
        tog_d = tog_q;
        if (advance) begin
            tog_d.ph = ~tog_q.ph;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_q <= '0;
        end else begin
            tog_q <= tog_d;
        end
    end

    assign phase = tog_q.ph;

endmodule

// File: rtl/fsr_read_mux.sv
module fsr_read_mux
    import fsr_pkg::*;
#(
    parameter int unsigned ADDR_W  = 19,
    parameter int unsigned DEV_SEL = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] array_data,
    input  logic              id_mode,
    input  logic              busy,
    input  logic              is_prog,
    input  logic              prog_msb,
    input  logic              phase,
    output logic [BYTE_W-1:0] rd_data
);

    localparam logic [BYTE_W-1:0] DEV_CODE = DEV_CODE_LOW + BYTE_W'(DEV_SEL % 4);

    typedef struct packed {
        logic [BYTE_W-1:0] data;
    } out_t;

    out_t out_d, out_q;
    logic [BYTE_W-1:0] status_byte;
    logic [BYTE_W-1:0] idle_byte;
    logic              at_maker;
    logic              at_device;

    assign at_maker  = (rd_addr == ADDR_W'(0));
    assign at_device = (rd_addr == ADDR_W'(1));

    always_comb begin
        status_byte           = array_data;
        status_byte[POLL_BIT] = is_prog ? ~prog_msb : 1'b0;
        status_byte[TOG_BIT]  = phase;
    end

    always_comb begin
        if (id_mode && at_maker) begin
            idle_byte = MAKER_CODE;
        end else if (id_mode && at_device) begin
            idle_byte = DEV_CODE;
        end else begin
            idle_byte = array_data;
        end
    end

    always_comb begin
        out_d = out_q;
        if (rd_en) begin
            out_d.data = busy ? status_byte : idle_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rd_data = out_q.data;

endmodule

// File: rtl/flash_status_resp.sv
module flash_status_resp
    import fsr_pkg::*;
#(
    parameter int unsigned ADDR_W   = 19,
    parameter int unsigned PROG_CYC = 20,
    parameter int unsigned SECT_CYC = 100,
    parameter int unsigned CHIP_CYC = 400,
    parameter int unsigned DEV_SEL  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic [1:0]        wr_op,
    input  logic [7:0]        wr_byte,
    input  logic              id_mode,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        array_data,
    output logic [7:0]        rd_data,
    output logic              busy
);

    logic st_busy;
    logic st_prog;
    logic st_msb;
    logic tog_phase;

    fsr_busy_timer #(
        .PROG_CYC (PROG_CYC),
        .SECT_CYC (SECT_CYC),
        .CHIP_CYC (CHIP_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (wr_start),
        .op       (op_kind_t'(wr_op)),
        .wr_msb   (wr_byte[POLL_BIT]),
        .busy     (st_busy),
        .is_prog  (st_prog),
        .prog_msb (st_msb)
    );

    fsr_toggle u_toggle (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (rd_en && st_busy),
        .phase   (tog_phase)
    );

    fsr_read_mux #(
        .ADDR_W  (ADDR_W),
        .DEV_SEL (DEV_SEL)
    ) u_rmux (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .array_data (array_data),
        .id_mode    (id_mode),
        .busy       (st_busy),
        .is_prog    (st_prog),
        .prog_msb   (st_msb),
        .phase      (tog_phase),
        .rd_data    (rd_data)
    );

    assign busy = st_busy;

endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
    parameter int unsigned ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_start,
    input logic [1:0]        wr_op,
    input logic              id_mode,
    input logic              rd_en,
    input logic [7:0]        array_data,
    input logic [7:0]        rd_data,
    input logic              busy,
    input logic              st_prog,
    input logic              st_msb,
    input logic              tog_phase
);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (busy == 1'b0 && rd_data == 8'h00 && tog_phase == 1'b0));

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_start && !busy && wr_op != 2'd3) |=> busy);

    p_noop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(wr_start && wr_op != 2'd3)) |=> !busy);

    p_prog_poll_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy && st_prog) |=> rd_data[7] == ~$past(st_msb));

    p_erase_poll_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy && !st_prog) |=> rd_data[7] == 1'b0);

    p_tog_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy) |=> rd_data[6] == $past(tog_phase));

    p_tog_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy) |=> tog_phase != $past(tog_phase));

    p_tog_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && busy) |=> $stable(tog_phase));

    p_idle_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !busy && !id_mode) |=> rd_data == $past(array_data));

    p_low_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy) |=> rd_data[5:0] == $past(array_data[5:0]));

    p_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

bind flash_status_resp fsr_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_start   (wr_start),
    .wr_op      (wr_op),
    .id_mode    (id_mode),
    .rd_en      (rd_en),
    .array_data (array_data),
    .rd_data    (rd_data),
    .busy       (busy),
    .st_prog    (st_prog),
    .st_msb     (st_msb),
    .tog_phase  (tog_phase)
);

// File: tb/sim_flash_status_resp.sv
`timescale 1ns/1ps
module sim_flash_status_resp;

    localparam int AW   = 16;
    localparam int PC   = 6;
    localparam int SC   = 10;
    localparam int CC   = 14;
    localparam int DSEL = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_start = 1'b0;
    logic [1:0]    wr_op = 2'd3;
    logic [7:0]    wr_byte = 8'h00;
    logic          id_mode = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    array_data = 8'h00;
    logic [7:0]    rd_data;
    logic          busy;

    int checks = 0;
    int errors = 0;
    int busy_seen = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    flash_status_resp #(
        .ADDR_W(AW), .PROG_CYC(PC), .SECT_CYC(SC), .CHIP_CYC(CC), .DEV_SEL(DSEL)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_op(wr_op),
        .wr_byte(wr_byte), .id_mode(id_mode), .rd_en(rd_en), .rd_addr(rd_addr),
        .array_data(array_data), .rd_data(rd_data), .busy(busy)
    );

    // behavioural reference model
    int         m_left = 0;
    bit         m_tog = 0;
    bit         m_prog = 0;
    bit         m_msb = 0;
    logic [7:0] m_out = 8'h00;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_left = 0; m_tog = 0; m_prog = 0; m_msb = 0; m_out = 8'h00;
        end else begin
            if (rd_en) begin
                if (m_left > 0) begin
                    m_out    = array_data;
                    m_out[7] = m_prog ? ~m_msb : 1'b0;
                    m_out[6] = m_tog;
                    m_tog    = ~m_tog;
                end else if (id_mode && rd_addr == 0) begin
                    m_out = 8'hBF;
                end else if (id_mode && rd_addr == 1) begin
                    m_out = 8'hD4 + 8'(DSEL);
                end else begin
                    m_out = array_data;
                end
            end
            if (m_left > 0) begin
                m_left = m_left - 1;
            end else if (wr_start && wr_op != 2'd3) begin
                m_left = (wr_op == 2'd0) ? PC : (wr_op == 2'd1) ? SC : CC;
                m_prog = (wr_op == 2'd0);
                m_msb  = wr_byte[7];
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (busy) busy_seen++;
        chk("R11 model rd_data", rd_data, m_out);
        chk("R2 model busy", busy, (m_left > 0) ? 1 : 0);
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] d, output logic [7:0] v);
        rd_en = 1'b1; rd_addr = a; array_data = d;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic start(input logic [1:0] op, input logic [7:0] b);
        wr_start = 1'b1; wr_op = op; wr_byte = b;
        @(negedge clk);
        wr_start = 1'b0; wr_op = 2'd3;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    initial begin
        logic [7:0] v1, v2;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", busy, 0);
        chk("R1 rd_data in reset", rd_data, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", busy, 0);

        rd(16'h0010, 8'hA5, v1); chk("R7 idle read", v1, 8'hA5);
        rd(16'h0011, 8'hFF, v1); chk("R7 erased reads FF", v1, 8'hFF);

        id_mode = 1'b1;
        rd(16'h0000, 8'h77, v1); chk("R8 maker code", v1, 8'hBF);
        rd(16'h0001, 8'h77, v1); chk("R8 device code", v1, 8'hD6);
        rd(16'h0002, 8'h77, v1); chk("R8 other address", v1, 8'h77);
        id_mode = 1'b0;
        rd(16'h0000, 8'h33, v1); chk("R8 id off", v1, 8'h33);

        // program, written msb 0
        busy_seen = 0;
        start(2'd0, 8'h3C);
        rd(16'h0040, 8'h3C, v1);
        chk("R4 program poll bit", v1[7], 1);
        chk("R10 low bits", v1[5:0], 8'h3C & 8'h3F);
        rd(16'h0040, 8'h3C, v2);
        chk("R6 toggle alternates", v2[6], ~v1[6] & 1'b1);
        chk("R4 program poll bit again", v2[7], 1);
        @(negedge clk);
        chk("R11 hold without strobe", rd_data, v2);
        start(2'd1, 8'hFF);
        wait_idle();
        chk("R2 R3 program length kept", busy_seen, PC);
        @(negedge clk);
        chk("R3 ignored start not queued", busy, 0);
        rd(16'h0040, 8'h3C, v1); chk("R7 done data", v1, 8'h3C);
        rd(16'h0040, 8'h3C, v2); chk("R7 no toggle when idle", v2, 8'h3C);

        // sector erase
        busy_seen = 0;
        start(2'd1, 8'h00);
        rd(16'h1000, 8'hFF, v1);
        chk("R5 sector poll bit", v1[7], 0);
        id_mode = 1'b1;
        rd(16'h0000, 8'hFF, v2);
        chk("R9 status over id", v2, {1'b0, ~v1[6], 6'h3F});
        id_mode = 1'b0;
        wait_idle();
        chk("R2 sector length", busy_seen, SC);

        // chip erase, written msb 1 must not matter
        busy_seen = 0;
        start(2'd2, 8'h80);
        rd(16'h0123, 8'h80, v1);
        chk("R5 chip poll bit", v1[7], 0);
        chk("R10 chip low bits", v1[5:0], 0);
        wait_idle();
        chk("R2 chip length", busy_seen, CC);

        // program, written msb 1, gaps between reads
        busy_seen = 0;
        start(2'd0, 8'h80);
        rd(16'h0200, 8'h12, v1);
        chk("R4 program poll msb1", v1[7], 0);
        @(negedge clk);
        @(negedge clk);
        rd(16'h0200, 8'h12, v2);
        chk("R6 alternates across gap", v2[6], ~v1[6] & 1'b1);
        wait_idle();
        chk("R2 program length", busy_seen, PC);

        start(2'd3, 8'h00);
        chk("R2 code 3 starts nothing", busy, 0);
        @(negedge clk);
        chk("R2 code 3 still idle", busy, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule